// File: doc/BRIEF.md
# Binary Associative Memory Recall Engine

This block runs the recall step of a binary correlation matrix memory. A sparse input code arrives as a stream of row numbers, one for each set bit. Every row number causes one read of a wide weight row from an external synchronous RAM. Each bit of that row is added into a counter that belongs to its output column. The row is processed as several 32-bit slices that work side by side.

When the final row number has been accepted and the read pipeline has drained, every column counter is compared against one global threshold. The resulting binary separator is sent out as a burst of 32-bit words, followed by a single-cycle completion pulse.

The threshold can be supplied explicitly. It can also be set automatically to the number of row numbers in the recall, which gives exact-match recall. A threshold below that count also passes the columns of stored patterns that match only in part.

Top module: `cmm_recall`

## Requirements
- R1: At the end of a recall, the counter for column c equals the number of accepted row numbers whose weight row has bit c set. A row number given twice is counted twice.
- R2: Output bit c is 1 exactly when the counter for column c is greater than or equal to the active threshold. A threshold of 0 gives all ones. A threshold above the row count gives all zeros.
- R3: The active threshold is captured in the same cycle as the row number marked last. When `thr_auto` is 1 in that cycle, the active threshold equals the number of row numbers accepted in the recall, and `threshold` is ignored.
- R4: With the threshold one below the row count, columns set in all but one of the selected rows also produce a 1.
- R5: One row number is accepted on every clock edge where `idx_valid` and `idx_ready` are both high. Idle cycles inside a recall leave the result unchanged.
- R6: After the edge that accepts a row number, `mem_rd_en` is 1 and `mem_rd_addr` equals that row number. Read data is expected one cycle later.
- R7: The separator leaves as SEP_W/32 words on consecutive cycles. Word k carries columns 32k to 32k+31, with bit j of the word being column 32k+j. Word 0 is valid 5 clock edges after the edge that accepts the last row number.
- R8: `done` is high for exactly one cycle, the cycle after the final word. `idx_ready` stays low from the edge that accepts the last row number until `done` is high.
- R9: Counters start from zero in every recall, so earlier recalls have no effect on the result.
- R10: A column that receives MAX_IDX hits, the largest recall allowed, reaches a count of MAX_IDX without wrapping.
- R11: After reset, `out_valid`, `done` and `mem_rd_en` are 0 and `idx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_valid | input | 1 | A row number is offered |
| idx_ready | output | 1 | Row numbers can be accepted |
| idx_data | input | IDX_W | Weight row number |
| idx_last | input | 1 | Marks the final row number of the recall |
| threshold | input | CNT_W | Explicit threshold, captured with the last row number |
| thr_auto | input | 1 | Use the row count as the threshold |
| mem_rd_en | output | 1 | Weight RAM read strobe |
| mem_rd_addr | output | IDX_W | Weight RAM row address |
| mem_rd_data | input | SEP_W | Weight row, valid one cycle after the read strobe |
| out_valid | output | 1 | Separator word valid |
| out_data | output | 32 | Thresholded separator word |
| done | output | 1 | Single-cycle completion pulse |

## Verification
Two conditions are hard to reach from the ports. The first is a column counter at its largest legal value. The bench reaches it by selecting an all-ones row MAX_IDX times, with the threshold equal to MAX_IDX. The second is a stale count leaking into the next recall. The bench exposes it by following that saturating recall with a recall of an all-zero row at threshold 1. In that case any leftover count would show up as set output bits. Pauses in the row-number stream, repeated row numbers and the automatic threshold are covered by rows of the stimulus table. Their expected separators come from a column-by-column count in the bench.

// File: rtl/cmm_pkg.sv
`timescale 1ns/1ps
package cmm_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RUN,
      ST_DRAIN,
      ST_EMIT,
      ST_FIN
   } cmm_state_e;

   function automatic int sel_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/cmm_fetch.sv
`timescale 1ns/1ps
// Stages 1..4 of the accumulate pipeline: address issue, RAM, row capture, retime.
module cmm_fetch #(
   parameter int IDX_W = 8,
   parameter int SEP_W = 96
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             idx_fire,
   input  logic [IDX_W-1:0] idx_data,
   input  logic             idx_last,
   output logic             mem_rd_en,
   output logic [IDX_W-1:0] mem_rd_addr,
   input  logic [SEP_W-1:0] mem_rd_data,
   output logic             acc_en,
   output logic             acc_last,
   output logic [SEP_W-1:0] acc_row
);
   logic             v1, v2, v3, v4;
   logic             l1, l2, l3, l4;
   logic [IDX_W-1:0] addr_q;
   logic [SEP_W-1:0] row3, row4;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0; v4 <= 1'b0;
         l1 <= 1'b0; l2 <= 1'b0; l3 <= 1'b0; l4 <= 1'b0;
         addr_q <= '0;
      end else begin
         v1 <= idx_fire;
         l1 <= idx_fire & idx_last;
         if (idx_fire) addr_q <= idx_data;
         v2 <= v1; l2 <= l1;
         v3 <= v2; l3 <= l2;
         v4 <= v3; l4 <= l3;
      end
   end

   always_ff @(posedge clk) begin
      row3 <= mem_rd_data;
      row4 <= row3;
   end

   assign mem_rd_en   = v1;
   assign mem_rd_addr = addr_q;
   assign acc_en      = v4;
   assign acc_last    = v4 & l4;
   assign acc_row     = row4;
endmodule

// File: rtl/cmm_acc_slice.sv
`timescale 1ns/1ps
// Stage 5: one column counter per bit of a slice, plus threshold compare.
module cmm_acc_slice #(
   parameter int SLICE_W = 32,
   parameter int CNT_W   = 4,
   parameter int MAX_CNT = 15
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               acc_en,
   input  logic [SLICE_W-1:0] row,
   input  logic [CNT_W-1:0]   thr,
   output logic [SLICE_W-1:0] hit
);
   if (MAX_CNT >= (1 << CNT_W)) begin : g_bad_cnt
      $error("cmm_acc_slice: CNT_W too narrow for MAX_CNT");
   end

   for (genvar c = 0; c < SLICE_W; c++) begin : g_col
      logic [CNT_W-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                cnt <= '0;
         else if (clr)              cnt <= '0;
         else if (acc_en && row[c]) cnt <= cnt + 1'b1;
      end

      assign hit[c] = (cnt >= thr);

      // R10
      no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_en && row[c]) |-> (cnt != CNT_W'(MAX_CNT)));

      // R9
      clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         clr |=> (cnt == '0));
   end
endmodule

// File: rtl/cmm_ctrl.sv
`timescale 1ns/1ps
// Recall sequencing, threshold capture and separator word emission.
module cmm_ctrl
   import cmm_pkg::*;
#(
   parameter int NSLICE  = 3,
   parameter int SLICE_W = 32,
   parameter int CNT_W   = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      idx_valid,
   input  logic                      idx_last,
   input  logic [CNT_W-1:0]          threshold,
   input  logic                      thr_auto,
   input  logic                      acc_last,
   input  logic [NSLICE*SLICE_W-1:0] hits,
   output logic                      idx_ready,
   output logic                      idx_fire,
   output logic                      clr,
   output logic [CNT_W-1:0]          thr_q,
   output logic                      out_valid,
   output logic [SLICE_W-1:0]        out_data,
   output logic                      done
);
   localparam int WSEL_W = sel_width(NSLICE);
   localparam logic [WSEL_W-1:0] WSEL_LAST = WSEL_W'(NSLICE - 1);

   cmm_state_e       st;
   logic [CNT_W-1:0] idx_cnt;
   logic [WSEL_W-1:0] wsel;

   assign idx_ready = (st == ST_IDLE) || (st == ST_RUN);
   assign idx_fire  = idx_valid && idx_ready;
   assign clr       = (st == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         thr_q     <= '0;
         idx_cnt   <= '0;
         wsel      <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
         done      <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         done      <= 1'b0;
         unique case (st)
            ST_IDLE, ST_RUN: begin
               if (idx_fire) begin
                  if (idx_last) begin
                     st      <= ST_DRAIN;
                     thr_q   <= thr_auto ? (idx_cnt + 1'b1) : threshold;
                     idx_cnt <= '0;
                  end else begin
                     st      <= ST_RUN;
                     idx_cnt <= idx_cnt + 1'b1;
                  end
               end
            end
            ST_DRAIN: begin
               if (acc_last) begin
                  st   <= ST_EMIT;
                  wsel <= '0;
               end
            end
            ST_EMIT: begin
               out_valid <= 1'b1;
               out_data  <= hits[int'(wsel)*SLICE_W +: SLICE_W];
               if (wsel == WSEL_LAST) st <= ST_FIN;
               else                   wsel <= wsel + 1'b1;
            end
            ST_FIN: begin
               done <= 1'b1;
               st   <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R8
   busy_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !idx_ready);

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(out_valid) && !out_valid));
endmodule

// File: rtl/cmm_recall.sv
`timescale 1ns/1ps
module cmm_recall #(
   parameter int SEP_W   = 96,
   parameter int SLICE_W = 32,
   parameter int IDX_W   = 8,
   parameter int MAX_IDX = 15,
   localparam int CNT_W  = $clog2(MAX_IDX + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               idx_valid,
   output logic               idx_ready,
   input  logic [IDX_W-1:0]   idx_data,
   input  logic               idx_last,
   input  logic [CNT_W-1:0]   threshold,
   input  logic               thr_auto,
   output logic               mem_rd_en,
   output logic [IDX_W-1:0]   mem_rd_addr,
   input  logic [SEP_W-1:0]   mem_rd_data,
   output logic               out_valid,
   output logic [SLICE_W-1:0] out_data,
   output logic               done
);
   localparam int NSLICE = SEP_W / SLICE_W;

   if ((SEP_W % SLICE_W) != 0 || NSLICE < 1) begin : g_bad_width
      $error("cmm_recall: SEP_W must be a positive multiple of SLICE_W");
   end
   if (MAX_IDX < 1) begin : g_bad_depth
      $error("cmm_recall: MAX_IDX must be at least 1");
   end

   logic             idx_fire;
   logic             clr;
   logic [CNT_W-1:0] thr_q;
   logic             acc_en;
   logic             acc_last;
   logic [SEP_W-1:0] acc_row;
   logic [SEP_W-1:0] hits;

   cmm_fetch #(.IDX_W(IDX_W), .SEP_W(SEP_W)) u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .idx_fire   (idx_fire),
      .idx_data   (idx_data),
      .idx_last   (idx_last),
      .mem_rd_en  (mem_rd_en),
      .mem_rd_addr(mem_rd_addr),
      .mem_rd_data(mem_rd_data),
      .acc_en     (acc_en),
      .acc_last   (acc_last),
      .acc_row    (acc_row)
   );

   for (genvar s = 0; s < NSLICE; s++) begin : g_slice
      cmm_acc_slice #(.SLICE_W(SLICE_W), .CNT_W(CNT_W), .MAX_CNT(MAX_IDX)) u_slc (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (clr),
         .acc_en(acc_en),
         .row   (acc_row[s*SLICE_W +: SLICE_W]),
         .thr   (thr_q),
         .hit   (hits[s*SLICE_W +: SLICE_W])
      );
   end

   cmm_ctrl #(.NSLICE(NSLICE), .SLICE_W(SLICE_W), .CNT_W(CNT_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx_valid(idx_valid),
      .idx_last (idx_last),
      .threshold(threshold),
      .thr_auto (thr_auto),
      .acc_last (acc_last),
      .hits     (hits),
      .idx_ready(idx_ready),
      .idx_fire (idx_fire),
      .clr      (clr),
      .thr_q    (thr_q),
      .out_valid(out_valid),
      .out_data (out_data),
      .done     (done)
   );

   // R7
   first_word_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_last |-> ##2 out_valid);
endmodule

// File: tb/sim_cmm_recall.sv
`timescale 1ns/1ps
module sim_cmm_recall;
   localparam int SEP_W = 96;
   localparam int NW    = 3;
   localparam int NV    = 9;

   // {pad, gap, auto, thr, n, i3, i2, i1, i0}
   localparam logic [47:0] VEC [NV] = '{
      {6'd0, 1'b0, 1'b0, 4'd3, 4'd3, 8'd0,   8'd200, 8'd9,  8'd5},
      {6'd0, 1'b0, 1'b0, 4'd2, 4'd3, 8'd0,   8'd200, 8'd9,  8'd5},
      {6'd0, 1'b0, 1'b1, 4'd0, 4'd3, 8'd0,   8'd200, 8'd9,  8'd5},
      {6'd0, 1'b1, 1'b0, 4'd1, 4'd4, 8'd130, 8'd77,  8'd33, 8'd17},
      {6'd0, 1'b0, 1'b0, 4'd1, 4'd1, 8'd0,   8'd0,   8'd0,  8'd42},
      {6'd0, 1'b0, 1'b0, 4'd2, 4'd2, 8'd0,   8'd0,   8'd42, 8'd42},
      {6'd0, 1'b0, 1'b0, 4'd0, 4'd4, 8'd255, 8'd0,   8'd3,  8'd3},
      {6'd0, 1'b0, 1'b0, 4'd3, 4'd2, 8'd0,   8'd0,   8'd255,8'd255},
      {6'd0, 1'b1, 1'b1, 4'd9, 4'd4, 8'd14,  8'd13,  8'd12, 8'd11}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        idx_valid = 1'b0;
   logic        idx_ready;
   logic [7:0]  idx_data = '0;
   logic        idx_last = 1'b0;
   logic [3:0]  threshold = '0;
   logic        thr_auto = 1'b0;
   logic        mem_rd_en;
   logic [7:0]  mem_rd_addr;
   logic [95:0] mem_rd_data;
   logic        out_valid;
   logic [31:0] out_data;
   logic        done;

   int checks = 0;
   int errors = 0;
   int idxs [16];

   always #2.5 clk = ~clk;

   cmm_recall u0 (
      .clk(clk), .rst_n(rst_n), .idx_valid(idx_valid), .idx_ready(idx_ready),
      .idx_data(idx_data), .idx_last(idx_last), .threshold(threshold),
      .thr_auto(thr_auto), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
      .mem_rd_data(mem_rd_data), .out_valid(out_valid), .out_data(out_data),
      .done(done)
   );

   function automatic logic [95:0] rowgen(int r);
      logic [95:0] w;
      for (int c = 0; c < 96; c++) w[c] = (((r*5 + c*3 + (r*c) % 7) % 4) == 0);
      if (r == 255) w = '1;
      if (r == 0)   w = '0;
      return w;
   endfunction

   always_ff @(posedge clk) if (mem_rd_en) mem_rd_data <= rowgen(int'(mem_rd_addr));

   function automatic logic [95:0] ref_bits(int n, int thr);
      logic [95:0] b;
      logic [95:0] rw;
      for (int c = 0; c < 96; c++) begin
         int cnt = 0;
         for (int i = 0; i < n; i++) begin
            rw = rowgen(idxs[i]);
            cnt += int'(rw[c]);
         end
         b[c] = (cnt >= thr);
      end
      return b;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_recall(input int n, input int thr, input bit auto_t, input bit gap, input string tag);
      logic [95:0] exp_b;
      logic [95:0] got;
      int ed, first_ed, nwords;
      bit seen_done;
      exp_b = ref_bits(n, auto_t ? n : thr);
      @(negedge clk);
      while (!idx_ready) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         if (gap && i == 1) begin
            idx_valid = 1'b0;
            repeat (2) @(negedge clk);
         end
         chk(idx_ready, "R5 ready while streaming", 96'(idx_ready), 96'd1);
         idx_valid = 1'b1;
         idx_data  = 8'(idxs[i]);
         idx_last  = (i == n-1);
         threshold = 4'(thr);
         thr_auto  = auto_t;
         @(posedge clk);
         @(negedge clk);
         // R6 read issued one cycle after accept
         chk(mem_rd_en && mem_rd_addr == 8'(idxs[i]), "R6 read address",
             {87'd0, mem_rd_en, mem_rd_addr}, {87'd0, 1'b1, 8'(idxs[i])});
         idx_valid = 1'b0;
         idx_last  = 1'b0;
      end
      ed = 0; first_ed = -1; nwords = 0; seen_done = 1'b0; got = '0;
      while (!seen_done && ed < 40) begin
         @(posedge clk); ed++;
         @(negedge clk);
         if (out_valid) begin
            if (first_ed < 0) first_ed = ed;
            if (nwords < NW) got[nwords*32 +: 32] = out_data;
            chk(ed == first_ed + nwords, "R7 consecutive words", 96'(ed), 96'(first_ed + nwords));
            chk(!idx_ready, "R8 busy during output", 96'(idx_ready), 96'd0);
            nwords++;
         end
         if (done) begin
            seen_done = 1'b1;
            chk(ed == first_ed + NW, "R8 done after last word", 96'(ed), 96'(first_ed + NW));
         end
      end
      chk(first_ed == 5, "R7 first word latency", 96'(first_ed), 96'd5);
      chk(nwords == NW, "R7 word count", 96'(nwords), 96'(NW));
      chk(got == exp_b, tag, got, exp_b);
      @(posedge clk);
      @(negedge clk);
      chk(!done, "R8 done single cycle", 96'(done), 96'd0);
      chk(idx_ready, "R8 ready after done", 96'(idx_ready), 96'd1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(!out_valid, "R11 out_valid", 96'(out_valid), 96'd0);
      chk(!done, "R11 done", 96'(done), 96'd0);
      chk(idx_ready, "R11 idx_ready", 96'(idx_ready), 96'd1);
      chk(!mem_rd_en, "R11 mem_rd_en", 96'(mem_rd_en), 96'd0);

      // Table: R1 counts incl. duplicates, R2 compare, R3 auto threshold,
      // R4 partial match, R5 gaps in the stream
      for (int v = 0; v < NV; v++) begin
         logic [47:0] e;
         e = VEC[v];
         for (int i = 0; i < 4; i++) idxs[i] = int'(e[8*i +: 8]);
         do_recall(int'(e[35:32]), int'(e[39:36]), e[40], e[41], "R1 R2 R3 R4 R5 separator");
      end

      // R10 counters reach MAX_IDX without wrapping
      for (int i = 0; i < 15; i++) idxs[i] = 255;
      do_recall(15, 15, 1'b0, 1'b0, "R10 full count");
      // R3 auto threshold at maximum count
      do_recall(15, 0, 1'b1, 1'b0, "R3 auto at max");
      // R9 no residue from previous recall
      idxs[0] = 0;
      do_recall(1, 1, 1'b0, 1'b0, "R9 cleared counters");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule